// File: doc/BRIEF.md
# Eight-Input Priority Interrupt Controller

This block collects up to eight interrupt request lines, tracks which of them are waiting, which are being serviced and which are blocked, and raises a single interrupt output towards a processor. Software drives it through a byte-wide register port with two addresses: a command address and a data address. A short initialization handshake fixes the vector base, the cascade wiring word and the end-of-interrupt mode. After that, command writes retire serviced interrupts and choose what a command-address read returns, and data writes load the mask.

When the processor pulses the acknowledge strobe, the controller returns in that same cycle an 8-bit vector. The vector is the programmed base with the winning input number in its three low bits. At the clock edge that ends the cycle, the winner moves from pending to in service. If nothing can be forwarded when acknowledge arrives, the controller answers with the vector of input 7 and changes no pending or in-service state. Several controllers can be chained: the cascade word written during initialization is held and presented on an output, so the surrounding logic can route acknowledges between controllers.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the interrupt output is low. The mask is all ones, so a data-address read returns 0xFF. Pending and in-service state are zero, command-address reads return the pending set, and the cascade output is 0x00.
- R2: A command-address write with bit 4 set starts initialization and clears the pending and in-service sets. The first data write after it sets the base. A cascade word follows only when bit 1 of the start word is 0, and a mode word follows only when bit 0 of the start word is 1. The mask is left unchanged.
- R3: With normal end-of-interrupt mode, an acknowledge that forwards input n clears pending bit n and sets in-service bit n.
- R4: The vector returned with acknowledge is bits 7:3 of the base word in bits 7:3 and the input number in bits 2:0. Bits 2:0 of the base word are ignored.
- R5: Mode word bit 1 set selects automatic end-of-interrupt, in which an acknowledge sets no in-service bit. Mode word bit 1 clear, or no mode word, selects normal mode.
- R6: Outside initialization, a data-address write loads the mask. A mask bit of 1 blocks its input from the interrupt output. A data-address read returns the mask.
- R7: Input 0 has the highest priority and input 7 the lowest. An unmasked pending input is forwarded only if its number is lower than every set in-service bit.
- R8: A rising edge on an input sets its pending bit. An input held high after it has been acknowledged does not request again.
- R9: A command write of 0x60+n clears in-service bit n. A command write of 0x20 clears the highest-priority in-service bit as it stood before that cycle.
- R10: A command write of 0x0A selects the pending set and 0x0B selects the in-service set for later command-address reads. The choice persists until it is changed and is reset to the pending set by initialization.
- R11: An acknowledge while nothing is forwarded returns base with 7 in bits 2:0, even when input 7 is masked, and changes no pending or in-service bit.
- R12: The cascade word is stored and driven on `casc_cfg`. A start word that omits it (bit 1 set) clears `casc_cfg` to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 selects the command address, 1 selects the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high, 0 otherwise |
| irq_in | input | 8 | Interrupt request lines, edge sensitive |
| ack | input | 1 | Single-cycle acknowledge strobe |
| int_out | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector returned during an acknowledge cycle |
| casc_cfg | output | 8 | Stored cascade configuration word |

## Verification
The bench builds the block with its default eight inputs and eight-bit data. With these values, every vector in the 0x00-0xFF space can be reached by reprogramming the base. Input 7 can also be checked both as a real request and as the spurious answer. Random re-initialization with all four start-word variants exercises every path through the init handshake. Random mixes of masks, in-service bits and both end-of-interrupt forms set up the priority cut-off against the in-service set at every input position.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    parameter int unsigned PIC_IN     = 8;
    parameter int unsigned PIC_DATA_W = 8;
    localparam int unsigned PIC_IDX_W = $clog2(PIC_IN);

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_BASE = 2'd1,
        ST_CASC = 2'd2,
        ST_MODE = 2'd3
    } init_st_e;

    typedef struct packed {
        init_st_e              st;
        logic                  single;
        logic                  need_mode;
        logic                  aeoi;
        logic                  rd_isr;
        logic [PIC_DATA_W-1:0] base;
        logic [PIC_DATA_W-1:0] casc;
        logic [PIC_IN-1:0]     imr;
        logic [PIC_IN-1:0]     irr;
        logic [PIC_IN-1:0]     isr;
        logic [PIC_IN-1:0]     prev;
    } pic_state_t;

endpackage

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int N = 8,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);

    logic [N-1:0] above;
    logic [N-1:0] first;

    generate
        for (genvar g = 0; g < N; g++) begin : g_bit
            if (g == 0) begin : g_top
                assign above[g] = 1'b0;
            end else begin : g_rest
                assign above[g] = |req[g-1:0];
            end
        end
    endgenerate

    assign first = req & ~above;
    assign any   = |req;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) begin
                idx = idx | W'(i);
            end
        end
    end

endmodule

// File: rtl/pic8_cmd_dec.sv
module pic8_cmd_dec #(
    parameter int DATA_W = 8
) (
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              is_init,
    output logic              is_spec_eoi,
    output logic              is_ns_eoi,
    output logic              is_sel,
    output logic              is_data
);

    logic cmd_wr;
    logic op_word;

    assign cmd_wr      = wr_en & ~addr;
    assign op_word     = cmd_wr & ~wdata[4] & ~wdata[3];
    assign is_init     = cmd_wr & wdata[4];
    assign is_spec_eoi = op_word & (wdata[7:5] == 3'b011);
    assign is_ns_eoi   = op_word & (wdata[7:5] == 3'b001);
    assign is_sel      = cmd_wr & ~wdata[4] & wdata[3] & wdata[1];
    assign is_data     = wr_en & addr;

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  addr,
    input  logic [PIC_DATA_W-1:0] wdata,
    output logic [PIC_DATA_W-1:0] rdata,
    input  logic [PIC_IN-1:0]     irq_in,
    input  logic                  ack,
    output logic                  int_out,
    output logic [PIC_DATA_W-1:0] vector,
    output logic [PIC_DATA_W-1:0] casc_cfg
);

    localparam int unsigned IDX_W = PIC_IDX_W;
    localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(PIC_IN - 1);

    pic_state_t state_q, state_d;

    logic [PIC_IN-1:0] pend;
    logic              p_any, isr_any, fwd;
    logic [IDX_W-1:0]  p_idx, isr_idx, sel_idx;
    logic              is_init, is_spec_eoi, is_ns_eoi, is_sel, is_data;

    logic [PIC_IN-1:0] cur_irr, cur_isr, cur_imr, cur_prev;
    logic              cur_aeoi;

    assign cur_irr  = state_q.irr;
    assign cur_isr  = state_q.isr;
    assign cur_imr  = state_q.imr;
    assign cur_prev = state_q.prev;
    assign cur_aeoi = state_q.aeoi;

    assign pend = state_q.irr & ~state_q.imr;

    pic8_prio #(.N(PIC_IN)) u_pend_prio (
        .req (pend),
        .any (p_any),
        .idx (p_idx)
    );

    pic8_prio #(.N(PIC_IN)) u_isr_prio (
        .req (state_q.isr),
        .any (isr_any),
        .idx (isr_idx)
    );

    pic8_cmd_dec #(.DATA_W(PIC_DATA_W)) u_dec (
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .is_init     (is_init),
        .is_spec_eoi (is_spec_eoi),
        .is_ns_eoi   (is_ns_eoi),
        .is_sel      (is_sel),
        .is_data     (is_data)
    );

    // Forward only when the best pending input outranks all in-service bits
    assign fwd      = p_any && (!isr_any || (p_idx < isr_idx));
    assign sel_idx  = fwd ? p_idx : SPUR_IDX;
    assign int_out  = fwd;
    assign vector   = {state_q.base[PIC_DATA_W-1:IDX_W], sel_idx};
    assign casc_cfg = state_q.casc;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr) begin
                rdata = PIC_DATA_W'(state_q.imr);
            end else if (state_q.rd_isr) begin
                rdata = PIC_DATA_W'(state_q.isr);
            end else begin
                rdata = PIC_DATA_W'(state_q.irr);
            end
        end
    end

    always_comb begin
        logic [PIC_IN-1:0] rising;
        state_d    = state_q;
        rising     = irq_in & ~state_q.prev;
        state_d.prev = irq_in;

        // acknowledge moves the winner out of pending
        if (ack && fwd) begin
            state_d.irr[p_idx] = 1'b0;
            if (!state_q.aeoi) begin
                state_d.isr[p_idx] = 1'b1;
            end
        end
        state_d.irr = state_d.irr | rising;

        if (is_spec_eoi) begin
            state_d.isr[wdata[IDX_W-1:0]] = 1'b0;
        end
        if (is_ns_eoi && isr_any) begin
            state_d.isr[isr_idx] = 1'b0;
        end
        if (is_sel) begin
            state_d.rd_isr = wdata[0];
        end

        if (is_init) begin
            state_d.st        = ST_BASE;
            state_d.single    = wdata[1];
            state_d.need_mode = wdata[0];
            state_d.aeoi      = 1'b0;
            state_d.rd_isr    = 1'b0;
            state_d.casc      = '0;
            state_d.irr       = '0;
            state_d.isr       = '0;
        end

        if (is_data) begin
            unique case (state_q.st)
                ST_BASE: begin
                    state_d.base = {wdata[PIC_DATA_W-1:IDX_W], {IDX_W{1'b0}}};
                    if (!state_q.single) begin
                        state_d.st = ST_CASC;
                    end else if (state_q.need_mode) begin
                        state_d.st = ST_MODE;
                    end else begin
                        state_d.st = ST_RUN;
                    end
                end
                ST_CASC: begin
                    state_d.casc = wdata;
                    state_d.st   = state_q.need_mode ? ST_MODE : ST_RUN;
                end
                ST_MODE: begin
                    state_d.aeoi = wdata[1];
                    state_d.st   = ST_RUN;
                end
                default: begin
                    state_d.imr = wdata[PIC_IN-1:0];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q           <= '0;
            state_q.st        <= ST_RUN;
            state_q.imr       <= '1;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/pic8_chk.sv
module pic8_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ack,
    input logic         wr_en,
    input logic         int_out,
    input logic         aeoi,
    input logic [N-1:0] irq_in,
    input logic [N-1:0] irr,
    input logic [N-1:0] isr,
    input logic [N-1:0] imr,
    input logic [N-1:0] prev
);

    a_r6_masked_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> ((irr & ~imr) != '0));

    a_r3_isr_gains_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !wr_en)
        |=> ($countones(isr) == $past($countones(isr)) + 1));

    a_r5_auto_eoi_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !wr_en) |=> (isr == $past(isr)));

    a_r11_spurious_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out && !wr_en)
        |=> ((isr == $past(isr)) && (irr == $past(irr | (irq_in & ~prev)))));

    a_r8_edge_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ((irr & $past(irq_in & ~prev)) == $past(irq_in & ~prev)));

endmodule

bind pic8_ctrl pic8_chk #(.N(pic8_pkg::PIC_IN)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ack),
    .wr_en   (wr_en),
    .int_out (int_out),
    .aeoi    (cur_aeoi),
    .irq_in  (irq_in),
    .irr     (cur_irr),
    .isr     (cur_isr),
    .imr     (cur_imr),
    .prev    (cur_prev)
);

// File: tb/sim_pic8_ctrl.sv
module sim_pic8_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0, irq_in = '0;
    logic [7:0] rdata, vector, casc_cfg;
    logic       int_out;

    int n_cmp = 0;
    int n_bad = 0;

    // reference state
    logic [7:0] m_irr, m_isr, m_imr, m_prev, m_base, m_casc;
    logic       m_aeoi, m_rdisr, m_single, m_need;
    int         m_st;

    logic       s_int;
    logic [7:0] s_vec, s_rd;

    pic8_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_in(irq_in), .ack(ack),
        .int_out(int_out), .vector(vector), .casc_cfg(casc_cfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int low_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    function automatic logic exp_fwd();
        int pi = low_idx(m_irr & ~m_imr);
        return (pi < 8) && (pi < low_idx(m_isr));
    endfunction

    function automatic logic [7:0] exp_vec();
        int pi = low_idx(m_irr & ~m_imr);
        return {m_base[7:3], exp_fwd() ? 3'(pi) : 3'd7};
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_irr = 0; m_isr = 0; m_imr = 8'hFF; m_prev = 0; m_base = 0; m_casc = 0;
        m_aeoi = 0; m_rdisr = 0; m_single = 0; m_need = 0; m_st = 0;
    endtask

    task automatic model_tick(input logic w, input logic a, input logic [7:0] d,
                              input logic k, input logic [7:0] irq);
        logic [7:0] n_irr = m_irr, n_isr = m_isr;
        int pi = low_idx(m_irr & ~m_imr);
        int ii = low_idx(m_isr);
        if (k && exp_fwd()) begin
            n_irr[pi] = 1'b0;
            if (!m_aeoi) n_isr[pi] = 1'b1;
        end
        n_irr = n_irr | (irq & ~m_prev);
        m_prev = irq;
        if (w && !a) begin
            if (d[4]) begin
                m_st = 1; m_single = d[1]; m_need = d[0]; m_aeoi = 0;
                m_rdisr = 0; m_casc = 0; n_irr = 0; n_isr = 0;
            end else if (d[3]) begin
                if (d[1]) m_rdisr = d[0];
            end else if (d[7:5] == 3'b011) begin
                n_isr[d[2:0]] = 1'b0;
            end else if (d[7:5] == 3'b001 && ii < 8) begin
                n_isr[ii] = 1'b0;
            end
        end else if (w && a) begin
            case (m_st)
                1: begin m_base = d & 8'hF8; m_st = !m_single ? 2 : (m_need ? 3 : 0); end
                2: begin m_casc = d; m_st = m_need ? 3 : 0; end
                3: begin m_aeoi = d[1]; m_st = 0; end
                default: m_imr = d;
            endcase
        end
        m_irr = n_irr; m_isr = n_isr;
    endtask

    // one clock cycle: drive, compare combinational outputs, advance model
    task automatic step(input logic w, input logic r, input logic a, input logic [7:0] d,
                        input logic k, input logic [7:0] irq);
        @(negedge clk);
        wr_en = w; rd_en = r; addr = a; wdata = d; ack = k; irq_in = irq;
        #1;
        s_int = int_out; s_vec = vector; s_rd = rdata;
        chk({7'd0, int_out}, {7'd0, exp_fwd()}, "R7 int_out");
        chk(casc_cfg, m_casc, "R12 casc_cfg");
        if (k) chk(vector, exp_vec(), exp_fwd() ? "R4 vector" : "R11 vector");
        if (r) chk(rdata, a ? m_imr : (m_rdisr ? m_isr : m_irr), a ? "R6 read" : "R10 read");
        @(posedge clk);
        model_tick(w, a, d, k, irq);
    endtask

    task automatic idle(input logic [7:0] irq);
        step(0, 0, 0, 8'h00, 0, irq);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] irq;
        void'($urandom(32'h0000_5EED));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk({7'd0, int_out}, 8'h00, "R1 int_out");
        chk(casc_cfg, 8'h00, "R1 casc_cfg");
        rd_en = 1; addr = 1; #1;
        chk(rdata, 8'hFF, "R1 mask read");
        rd_en = 0;
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 0, 8'h00, 0, 8'h00);
        chk(s_rd, 8'h00, "R1 pending read");

        // R2/R12: cascade init with mode word
        step(1, 0, 0, 8'h11, 0, 0);
        step(1, 0, 1, 8'h20, 0, 0);
        step(1, 0, 1, 8'h04, 0, 0);
        step(1, 1, 1, 8'h01, 0, 0);
        chk(s_rd, 8'hFF, "R2 mask kept");
        chk(casc_cfg, 8'h04, "R12 cascade word");
        step(1, 0, 1, 8'h00, 0, 0);               // R6 unmask all

        // R8/R3/R4: input 3 edge, held high
        irq = 8'h08;
        step(0, 0, 0, 0, 0, irq);
        step(0, 0, 0, 0, 0, irq);
        chk({7'd0, s_int}, 8'h01, "R8 edge raises int");
        step(0, 0, 0, 0, 1, irq);
        chk(s_vec, 8'h23, "R4 vector input3");
        step(0, 0, 0, 0, 0, irq);
        chk({7'd0, s_int}, 8'h00, "R8 held level no retrigger");
        step(1, 0, 0, 8'h0B, 0, irq);
        step(0, 1, 0, 0, 0, irq);
        chk(s_rd, 8'h08, "R3 R10 in-service read");
        // R7: lower priority blocked, higher forwarded
        irq = 8'h28;
        step(0, 0, 0, 0, 0, irq);
        step(0, 0, 0, 0, 0, irq);
        chk({7'd0, s_int}, 8'h00, "R7 input5 blocked by isr3");
        irq = 8'h2A;
        step(0, 0, 0, 0, 0, irq);
        step(0, 0, 0, 0, 1, irq);
        chk(s_vec, 8'h21, "R7 input1 outranks isr3");
        step(1, 0, 0, 8'h20, 0, irq);             // R9 nonspecific clears isr1
        step(0, 1, 0, 0, 0, irq);
        chk(s_rd, 8'h08, "R9 nonspecific eoi");
        step(1, 0, 0, 8'h63, 0, irq);             // R9 specific clears isr3
        step(0, 1, 0, 0, 0, irq);
        chk(s_rd, 8'h00, "R9 specific eoi");
        chk({7'd0, s_int}, 8'h01, "R7 input5 released");
        step(1, 0, 0, 8'h0A, 0, irq);
        step(0, 1, 0, 0, 0, irq);
        chk(s_rd, 8'h20, "R10 pending read");

        // R11: all masked, spurious answer
        step(1, 0, 1, 8'hFF, 0, irq);
        irq = 8'hAA;
        step(0, 0, 0, 0, 0, irq);
        step(0, 0, 0, 0, 1, irq);
        chk(s_vec, 8'h27, "R11 spurious vector");
        step(0, 1, 0, 0, 0, irq);
        chk(s_rd, 8'hA0, "R11 pending unchanged");

        // R5/R12: single mode, auto EOI
        irq = 8'h00;
        step(1, 0, 0, 8'h13, 0, irq);
        step(1, 0, 1, 8'h2D, 0, irq);
        step(1, 0, 1, 8'h03, 0, irq);
        chk(casc_cfg, 8'h00, "R12 no cascade word");
        step(1, 0, 1, 8'h00, 0, irq);
        irq = 8'h04;
        step(0, 0, 0, 0, 0, irq);
        step(0, 0, 0, 0, 1, irq);
        chk(s_vec, 8'h2A, "R4 R5 vector base 0x28");
        step(1, 0, 0, 8'h0B, 0, irq);
        step(0, 1, 0, 0, 0, irq);
        chk(s_rd, 8'h00, "R5 auto eoi leaves isr clear");

        // random phase
        for (int c = 0; c < 4000; c++) begin
            logic       w, r, a, k;
            logic [7:0] d;
            if ($urandom % 4 == 0) irq = irq ^ 8'($urandom & $urandom);
            w = ($urandom % 6 == 0);
            r = ($urandom % 2 == 0);
            k = ($urandom % 4 == 0);
            a = 1'($urandom);
            d = 8'($urandom);
            if (w && !a) begin
                case ($urandom % 8)
                    0, 1, 2, 3: d = 8'h60 | 8'($urandom % 8);
                    4: d = 8'h20;
                    5: d = 8'h0A;
                    6: d = 8'h0B;
                    default: d = ($urandom % 6 == 0) ? (8'h10 | 8'($urandom % 4)) : 8'h0B;
                endcase
            end else if (w && a && m_st == 0) begin
                d = 8'($urandom & $urandom);
            end
            step(w, r, a, d, k, irq);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule